// File: doc/BRIEF.md
# Fixed-Priority Interrupt Request Controller

This block collects up to eight interrupt request lines on behalf of a host processor. A rising edge on any request line records that request in a pending register. The block then raises a single interrupt output whenever a pending request outranks everything the host is currently servicing. Priority is fixed: line 0 ranks highest and the last line ranks lowest.

The host answers with an acknowledge strobe. The block grants the best pending request, moves it from the pending register to the in-service register, and returns a vector one cycle later. The vector is the vector base plus the line index. Service ends only when the host issues an explicit end-of-interrupt strobe. Until then, requests of equal or lower rank are held back, while requests of higher rank can still nest.

Both the pending and in-service registers are visible on the outputs, so the host or a neighbouring block can inspect them.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A rising edge (low in one cycle, high in the next) on request line i sets pending bit i at that clock edge, whether or not a request is being serviced. A line held high sets the bit only once.
- R2: `irq_o` is high while an eligible pending request exists. It stays high when a further, higher-ranked request arrives before acknowledge.
- R3: Priority is fixed: a lower line index always ranks above a higher index.
- R4: When `ack_i` is sampled high while `irq_o` is high, `vec_o` equals `vec_base_i` plus the granted index in the next cycle, modulo 2^VW. `vec_valid_o` is high in that cycle only. An `ack_i` while `irq_o` is low leaves `vec_valid_o` low and changes neither register.
- R5: A grant clears the granted pending bit and sets the matching in-service bit at the same clock edge.
- R6: A pending request is eligible only if its index is strictly lower than the index of every set in-service bit.
- R7: `eoi_i` clears the lowest-index set in-service bit. It has no effect when the in-service register is empty.
- R8: A synchronous active-high reset clears both registers, `vec_valid_o` and `irq_o`.
- R9: If an end-of-interrupt makes a still-pending request eligible, `irq_o` is high in the cycle right after that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | N | Request lines; bit 0 ranks highest |
| ack_i | input | 1 | Host acknowledge strobe |
| eoi_i | input | 1 | End-of-interrupt strobe |
| vec_base_i | input | VW | Base added to the granted index |
| irq_o | output | 1 | Interrupt to host |
| vec_o | output | VW | Vector of the last grant |
| vec_valid_o | output | 1 | High for one cycle after a grant |
| pend_o | output | N | Pending request register |
| insvc_o | output | N | In-service register |

## Verification
The bench builds the block with its default values of eight lines and an 8-bit vector. This brings every rank from 0 to 7 within reach, including the lowest. For part of the run the vector base is set to 0xFC, so a grant of a high index wraps past the top of the vector width. The directed tests nest a higher-ranked grant inside a lower one, retire the two with successive end-of-interrupt strobes, and hold a request line high across its own grant to show that a level alone does not re-arm the line.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int N  = 8,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req_i,
  input  logic          ack_i,
  input  logic          eoi_i,
  input  logic [VW-1:0] vec_base_i,
  output logic          irq_o,
  output logic [VW-1:0] vec_o,
  output logic          vec_valid_o,
  output logic [N-1:0]  pend_o,
  output logic [N-1:0]  insvc_o
);
  localparam int IDW = $clog2(N) + 1;

  logic [N-1:0]  req_d, pend_q, insvc_q, edge_w, grant_oh, eoi_oh;
  logic [IDW-1:0] best_pend, best_isr;
  logic grant;

  function automatic logic [IDW-1:0] first_set(input logic [N-1:0] v);
    first_set = IDW'(N);
    for (int i = N - 1; i >= 0; i--)
      if (v[i]) first_set = IDW'(i);
  endfunction

  assign edge_w    = req_i & ~req_d;
  assign best_pend = first_set(pend_q);
  assign best_isr  = first_set(insvc_q);
  assign irq_o     = best_pend < best_isr;
  assign grant     = ack_i && irq_o;
  assign grant_oh  = grant ? (N'(1) << best_pend) : '0;
  assign eoi_oh    = (eoi_i && insvc_q != '0) ? (N'(1) << best_isr) : '0;
  assign pend_o    = pend_q;
  assign insvc_o   = insvc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d       <= '0;
      pend_q      <= '0;
      insvc_q     <= '0;
      vec_o       <= '0;
      vec_valid_o <= 1'b0;
    end else begin
      req_d       <= req_i;
      pend_q      <= (pend_q & ~grant_oh) | edge_w;
      insvc_q     <= (insvc_q & ~eoi_oh) | grant_oh;
      vec_valid_o <= grant;
      if (grant) vec_o <= vec_base_i + VW'(best_pend);
    end
  end

  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> (pend_q == '0 && insvc_q == '0 && !vec_valid_o && !irq_o));

  assert_valid_follows_grant_R4: assert property (@(posedge clk) disable iff (rst)
    vec_valid_o |-> $past(ack_i && irq_o));

  assert_one_grant_per_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    $countones(insvc_q & ~$past(insvc_q)) <= 1);

  assert_eoi_empty_noop_R7: assert property (@(posedge clk) disable iff (rst)
    (eoi_i && insvc_q == '0 && !ack_i) |=> insvc_q == '0);

  assert_irq_needs_pending_R2: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> pend_q != '0);

  assert_grant_moves_bit_R5: assert property (@(posedge clk) disable iff (rst)
    (ack_i && irq_o) |=> ($countones(insvc_q) == $countones($past(insvc_q)) + 1
                          - ($past(eoi_i && insvc_q != '0) ? 1 : 0)));
endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;
  logic clk = 0, rst = 1, ack = 0, eoi = 0;
  logic [7:0] req = '0, base = 8'h40;
  logic irq, vvalid;
  logic [7:0] vec, pend, insvc;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_prio_ctrl #(.N(8), .VW(8)) dut_i (
    .clk(clk), .rst(rst), .req_i(req), .ack_i(ack), .eoi_i(eoi),
    .vec_base_i(base), .irq_o(irq), .vec_o(vec), .vec_valid_o(vvalid),
    .pend_o(pend), .insvc_o(insvc));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic pulse_req(int i);
    req[i] = 1; step(); req[i] = 0; step();
  endtask

  task automatic do_ack(); ack = 1; step(); ack = 0; endtask
  task automatic do_eoi(); eoi = 1; step(); eoi = 0; endtask

  task automatic t_reset();
    rst = 1; step(); step(); rst = 0;
    chk("R8 irq", irq, 0); chk("R8 pend", pend, 0);
    chk("R8 insvc", insvc, 0); chk("R8 valid", vvalid, 0);
  endtask

  task automatic t_nest();
    pulse_req(3);
    chk("R1 pend set", pend, 8'h08); chk("R2 irq", irq, 1);
    pulse_req(1);
    chk("R2 irq stays", irq, 1); chk("R1 pend two", pend, 8'h0A);
    do_ack();
    chk("R3 vec rank", vec, 8'h41); chk("R4 valid", vvalid, 1);
    chk("R5 insvc", insvc, 8'h02); chk("R5 pend", pend, 8'h08);
    chk("R6 lower blocked", irq, 0);
    step();
    chk("R4 valid one cycle", vvalid, 0);
    pulse_req(1);
    chk("R6 equal blocked", irq, 0);
    pulse_req(0);
    chk("R6 higher nests", irq, 1);
    do_ack();
    chk("R4 vec0", vec, 8'h40); chk("R5 insvc nest", insvc, 8'h03);
    chk("R5 pend nest", pend, 8'h0A);
    do_eoi();
    chk("R7 clears top", insvc, 8'h02); chk("R6 still blocked", irq, 0);
    do_eoi();
    chk("R7 clears last", insvc, 8'h00); chk("R9 reassert", irq, 1);
    do_ack(); chk("R3 vec1", vec, 8'h41); do_eoi();
    chk("R9 next pending", irq, 1);
    do_ack(); chk("R3 vec3", vec, 8'h43); do_eoi();
    chk("R7 empty", insvc, 0); chk("R2 none", irq, 0);
  endtask

  task automatic t_noop();
    do_eoi();
    chk("R7 eoi empty", insvc, 0); chk("R7 eoi pend", pend, 0);
    do_ack();
    chk("R4 ack idle valid", vvalid, 0); chk("R4 ack idle insvc", insvc, 0);
  endtask

  task automatic t_level_wrap();
    base = 8'hFC;
    req[5] = 1; step();
    chk("R1 level set", pend, 8'h20);
    do_ack();
    chk("R4 wrap", vec, 8'h01);
    step(); step();
    chk("R1 level once", pend, 8'h00);
    req[7] = 1; step();
    chk("R6 lowest blocked", irq, 0);
    do_eoi();
    chk("R9 lowest up", irq, 1);
    do_ack(); chk("R4 wrap7", vec, 8'h03); do_eoi();
    req = '0; step();
  endtask

  initial begin
    step();
    t_reset();
    t_nest();
    t_noop();
    t_level_wrap();
    t_reset();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule